// File: doc/BRIEF.md
# Command-Slot Register Map Copier

This block moves the argument register map of one queued command from a command queue slot in memory into the register space of the compute unit that will run it. A controller picks a free unit and writes a one-hot unit mask into the slot's mask word. It then writes the slot index to the trigger register. From there the block works on its own. It reads the slot header, finds the destination unit from the mask words, and streams the remaining payload words to consecutive register addresses of that unit. The controller is never stalled while this runs.

The block is programmed through a small write-only register port. Through it the controller sets four values: the address of slot 0, the slot size in bytes, the address of unit 0, and the base-2 logarithm of the per-unit register span. The block reads the queue through a read port that allows one request in flight. It writes unit registers through a valid/ready write port. A `busy` flag and a one-cycle `done` pulse report progress. One extra trigger can wait in a single-entry pending register.

The controller is a single state machine with nine named states:
- `ST_IDLE`: waits for a pending trigger.
- `ST_HDR_REQ`, then `ST_HDR_WAIT`: fetch the header.
- `ST_MSK_REQ`, then `ST_MSK_WAIT`: scan the mask words.
- `ST_ARG_REQ`, then `ST_ARG_WAIT`: fetch one register-map word.
- `ST_ARG_WRITE`: hands that word to the write port.
- `ST_DONE`: raises `done` and returns to `ST_IDLE`.

The transitions are:
- `ST_IDLE` to `ST_HDR_REQ` when a trigger is pending.
- Each `*_REQ` state to its `*_WAIT` state unconditionally.
- `ST_HDR_WAIT` to `ST_MSK_REQ` on read data.
- `ST_MSK_WAIT` goes, on read data, to one of three states:
  - `ST_ARG_REQ` when the mask word is nonzero and the map is non-empty.
  - `ST_DONE` when the mask word is nonzero and the map is empty, or when the last mask word is zero.
  - `ST_MSK_REQ` for the next mask word otherwise.
- `ST_ARG_WAIT` to `ST_ARG_WRITE` on read data.
- `ST_ARG_WRITE` to `ST_ARG_REQ`, or to `ST_DONE` after the last word, on write acceptance.
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `slot_regmap_dma`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_valid` are all low.
- R2: Register writes are decoded on `cfg_addr` as follows:
  - 0: slot-0 byte address.
  - 1: slot size in bytes.
  - 2: unit-0 byte address.
  - 3: unit span shift, held in the low SHIFT_W bits.
  - 4: trigger, with the slot index in the low SLOT_IDX_W bits.
  The first read after a trigger is the header, at slot-0 address + index × slot size.
- R3: The header is decoded as follows:
  - Bits [22:12] give the payload word count.
  - Bits [11:10] give the number of extra mask words.
  - Every other header bit has no effect on the reads or writes.
- R4: Mask words are read at header address + 4, + 8, and so on.
  - The destination index is 32 × (position of the first nonzero mask word) + (its lowest set bit).
  - Mask reads stop at the first nonzero word.
- R5: Map word k is read from header address + 4 × (2 + extra + k). It is written to unit-0 address + (index << shift) + 4 × k, in increasing k, and a read is never requested while a write is offered.
- R6: The map length is count − (1 + extra). When that is zero or negative, nothing is written and `done` still pulses.
- R7: `done` is high for exactly one cycle, after the final write is accepted, or after the last mask read when nothing is written.
- R8: If every mask word is zero, nothing is written and `done` pulses.
- R9: While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` hold.
- R10: `busy` is high from the cycle after a trigger write until the cycle after `done`, and stays high if a trigger is pending. A trigger written while a copy runs, with the pending entry free, is started after the current copy finishes.
- R11: A trigger written while the pending entry is already occupied is dropped.
- R12: `rd_req` lasts one cycle and is not raised again until `rd_valid` has returned the requested word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| busy | output | 1 | Copy running or trigger pending |
| done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Queue read request |
| rd_addr | output | ADDR_W | Queue read byte address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data word |
| wr_valid | output | 1 | Unit register write offered |
| wr_addr | output | ADDR_W | Unit register byte address |
| wr_data | output | 32 | Unit register write data |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |

## Verification
The bench builds the block with ADDR_W = 32, SLOT_IDX_W = 4 and SHIFT_W = 5. It programs a 64-byte slot size and a shift of 16. Sixteen slots then fit in a 4 KiB memory model, and unit indices up to 127 map to well separated addresses. With these values the bench can reach:
- all four mask-word positions, including a destination index of 69 found in the third mask word;
- map lengths from empty to six words;
- an underflowing count;
- a write port that accepts only one cycle in four;
- three trigger writes in consecutive cycles, which fill and then overflow the pending entry.

// File: rtl/srd_pkg.sv
`timescale 1ns/1ps
package srd_pkg;
    localparam int WORD_W       = 32;
    localparam int CFG_ADDR_W   = 3;

    localparam logic [CFG_ADDR_W-1:0] CFG_QBASE  = 3'd0;
    localparam logic [CFG_ADDR_W-1:0] CFG_SLOTSZ = 3'd1;
    localparam logic [CFG_ADDR_W-1:0] CFG_UBASE  = 3'd2;
    localparam logic [CFG_ADDR_W-1:0] CFG_USHIFT = 3'd3;
    localparam logic [CFG_ADDR_W-1:0] CFG_TRIG   = 3'd4;

    // header field placement
    localparam int HDR_CNT_LSB  = 12;
    localparam int HDR_CNT_W    = 11;
    localparam int HDR_XM_LSB   = 10;
    localparam int HDR_XM_W     = 2;

    localparam int MASK_BITS    = 32;
    localparam int MASK_IDX_W   = $clog2(MASK_BITS);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_MSK_REQ,
        ST_MSK_WAIT,
        ST_ARG_REQ,
        ST_ARG_WAIT,
        ST_ARG_WRITE,
        ST_DONE
    } srd_state_e;
endpackage

// File: rtl/srd_cfg_regs.sv
`timescale 1ns/1ps
module srd_cfg_regs
    import srd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SLOT_IDX_W = 5,
    parameter int SHIFT_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    input  logic                  take,
    output logic [ADDR_W-1:0]     q_base,
    output logic [ADDR_W-1:0]     slot_bytes,
    output logic [ADDR_W-1:0]     u_base,
    output logic [SHIFT_W-1:0]    u_shift,
    output logic                  pend_vld,
    output logic [SLOT_IDX_W-1:0] pend_idx
);
    logic trig_wr;
    assign trig_wr = cfg_we && (cfg_addr == CFG_TRIG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_base     <= '0;
            slot_bytes <= '0;
            u_base     <= '0;
            u_shift    <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_QBASE:  q_base     <= cfg_wdata;
                CFG_SLOTSZ: slot_bytes <= cfg_wdata;
                CFG_UBASE:  u_base     <= cfg_wdata;
                CFG_USHIFT: u_shift    <= cfg_wdata[SHIFT_W-1:0];
                default: ;
            endcase
        end
    end

    // single pending entry: a trigger lands if the entry is free or being taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_idx <= '0;
        end else begin
            if (take) begin
                pend_vld <= 1'b0;
            end
            if (trig_wr && (!pend_vld || take)) begin
                pend_vld <= 1'b1;
                pend_idx <= cfg_wdata[SLOT_IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/srd_addr_calc.sv
`timescale 1ns/1ps
module srd_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int SLOT_IDX_W = 5,
    parameter int SHIFT_W    = 5,
    parameter int UNIT_IDX_W = 7
) (
    input  logic [ADDR_W-1:0]     q_base,
    input  logic [ADDR_W-1:0]     slot_bytes,
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    input  logic [ADDR_W-1:0]     u_base,
    input  logic [SHIFT_W-1:0]    u_shift,
    input  logic [UNIT_IDX_W-1:0] unit_idx,
    output logic [ADDR_W-1:0]     slot_addr,
    output logic [ADDR_W-1:0]     unit_addr
);
    always_comb begin
        slot_addr = q_base + slot_bytes * ADDR_W'(slot_idx);
        unit_addr = u_base + (ADDR_W'(unit_idx) << u_shift);
    end
endmodule

// File: rtl/srd_lsb_find.sv
`timescale 1ns/1ps
module srd_lsb_find #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/srd_ctrl.sv
`timescale 1ns/1ps
module srd_ctrl
    import srd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int UNIT_IDX_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pend_vld,
    input  logic [ADDR_W-1:0]     slot_addr_i,
    input  logic [ADDR_W-1:0]     unit_addr_i,
    input  logic                  bit_any,
    input  logic [MASK_IDX_W-1:0] bit_idx,
    output logic                  take,
    output logic [UNIT_IDX_W-1:0] unit_idx_o,
    output logic                  busy,
    output logic                  done,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_valid,
    input  logic [WORD_W-1:0]     rd_data,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [WORD_W-1:0]     wr_data,
    input  logic                  wr_ready
);
    srd_state_e              state_q, state_d;
    logic [ADDR_W-1:0]       slot_q;
    logic [ADDR_W-1:0]       unit_q;
    logic [HDR_XM_W-1:0]     extra_q;
    logic [HDR_XM_W-1:0]     mword_q;
    logic [HDR_CNT_W-1:0]    len_q;
    logic [HDR_CNT_W-1:0]    argk_q;
    logic [WORD_W-1:0]       data_q;

    logic [HDR_CNT_W-1:0]    hdr_cnt;
    logic [HDR_XM_W-1:0]     hdr_xm;
    logic [HDR_CNT_W-1:0]    hdr_need;
    logic [HDR_CNT_W-1:0]    hdr_len;
    logic                    last_arg;

    always_comb begin
        hdr_cnt  = rd_data[HDR_CNT_LSB +: HDR_CNT_W];
        hdr_xm   = rd_data[HDR_XM_LSB +: HDR_XM_W];
        hdr_need = HDR_CNT_W'(hdr_xm) + HDR_CNT_W'(1);
        hdr_len  = (hdr_cnt > hdr_need) ? (hdr_cnt - hdr_need) : '0;
        last_arg = (argk_q == (len_q - HDR_CNT_W'(1)));
    end

    assign unit_idx_o = {mword_q, bit_idx};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (pend_vld) state_d = ST_HDR_REQ;
            ST_HDR_REQ:   state_d = ST_HDR_WAIT;
            ST_HDR_WAIT:  if (rd_valid) state_d = ST_MSK_REQ;
            ST_MSK_REQ:   state_d = ST_MSK_WAIT;
            ST_MSK_WAIT: begin
                if (rd_valid) begin
                    if (bit_any) begin
                        state_d = (len_q == '0) ? ST_DONE : ST_ARG_REQ;
                    end else if (mword_q == extra_q) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_MSK_REQ;
                    end
                end
            end
            ST_ARG_REQ:   state_d = ST_ARG_WAIT;
            ST_ARG_WAIT:  if (rd_valid) state_d = ST_ARG_WRITE;
            ST_ARG_WRITE: if (wr_ready) state_d = last_arg ? ST_DONE : ST_ARG_REQ;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            unit_q  <= '0;
            extra_q <= '0;
            mword_q <= '0;
            len_q   <= '0;
            argk_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pend_vld) slot_q <= slot_addr_i;
                end
                ST_HDR_WAIT: begin
                    if (rd_valid) begin
                        extra_q <= hdr_xm;
                        len_q   <= hdr_len;
                        mword_q <= '0;
                    end
                end
                ST_MSK_WAIT: begin
                    if (rd_valid) begin
                        if (bit_any) begin
                            unit_q <= unit_addr_i;
                            argk_q <= '0;
                        end else begin
                            mword_q <= mword_q + HDR_XM_W'(1);
                        end
                    end
                end
                ST_ARG_WAIT: begin
                    if (rd_valid) data_q <= rd_data;
                end
                ST_ARG_WRITE: begin
                    if (wr_ready) argk_q <= argk_q + HDR_CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        take     = 1'b0;
        done     = 1'b0;
        rd_req   = 1'b0;
        rd_addr  = '0;
        wr_valid = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        busy     = (state_q != ST_IDLE) || pend_vld;
        unique case (state_q)
            ST_IDLE:    take = pend_vld;
            ST_HDR_REQ: begin
                rd_req  = 1'b1;
                rd_addr = slot_q;
            end
            ST_MSK_REQ: begin
                rd_req  = 1'b1;
                rd_addr = slot_q + ((ADDR_W'(mword_q) + ADDR_W'(1)) << 2);
            end
            ST_ARG_REQ: begin
                rd_req  = 1'b1;
                rd_addr = slot_q +
                          ((ADDR_W'(argk_q) + ADDR_W'(extra_q) + ADDR_W'(2)) << 2);
            end
            ST_ARG_WRITE: begin
                wr_valid = 1'b1;
                wr_addr  = unit_q + (ADDR_W'(argk_q) << 2);
                wr_data  = data_q;
            end
            ST_DONE:    done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/slot_regmap_dma.sv
`timescale 1ns/1ps
module slot_regmap_dma
    import srd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SLOT_IDX_W = 5,
    parameter int SHIFT_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_valid,
    input  logic [WORD_W-1:0]     rd_data,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [WORD_W-1:0]     wr_data,
    input  logic                  wr_ready
);
    localparam int UNIT_IDX_W = HDR_XM_W + MASK_IDX_W;

    logic [ADDR_W-1:0]     q_base, slot_bytes, u_base;
    logic [SHIFT_W-1:0]    u_shift;
    logic                  pend_vld, take;
    logic [SLOT_IDX_W-1:0] pend_idx;
    logic [ADDR_W-1:0]     slot_addr, unit_addr;
    logic [UNIT_IDX_W-1:0] unit_idx;
    logic                  bit_any;
    logic [MASK_IDX_W-1:0] bit_idx;

    srd_cfg_regs #(
        .ADDR_W(ADDR_W), .SLOT_IDX_W(SLOT_IDX_W), .SHIFT_W(SHIFT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .take(take),
        .q_base(q_base), .slot_bytes(slot_bytes), .u_base(u_base),
        .u_shift(u_shift), .pend_vld(pend_vld), .pend_idx(pend_idx)
    );

    srd_addr_calc #(
        .ADDR_W(ADDR_W), .SLOT_IDX_W(SLOT_IDX_W),
        .SHIFT_W(SHIFT_W), .UNIT_IDX_W(UNIT_IDX_W)
    ) u_addr (
        .q_base(q_base), .slot_bytes(slot_bytes), .slot_idx(pend_idx),
        .u_base(u_base), .u_shift(u_shift), .unit_idx(unit_idx),
        .slot_addr(slot_addr), .unit_addr(unit_addr)
    );

    srd_lsb_find #(.W(MASK_BITS)) u_lsb (
        .vec(rd_data), .any(bit_any), .idx(bit_idx)
    );

    srd_ctrl #(.ADDR_W(ADDR_W), .UNIT_IDX_W(UNIT_IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pend_vld(pend_vld), .slot_addr_i(slot_addr), .unit_addr_i(unit_addr),
        .bit_any(bit_any), .bit_idx(bit_idx),
        .take(take), .unit_idx_o(unit_idx),
        .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );
endmodule

// File: rtl/srd_checker.sv
`timescale 1ns/1ps
module srd_checker
    import srd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [CFG_ADDR_W-1:0] cfg_addr,
    input logic                  busy,
    input logic                  done,
    input logic                  rd_req,
    input logic                  rd_valid,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [WORD_W-1:0]     wr_data
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_valid && !done)); // R1

    AST_RD_NO_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_valid)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

    AST_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_TRIG) |=> busy); // R10

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R12

    AST_RD_WAIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !rd_valid && $past(rd_req)) |=> !rd_req); // R12
endmodule

bind slot_regmap_dma srd_checker #(.ADDR_W(ADDR_W)) u_srd_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_valid(rd_valid),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/slot_regmap_dma_tb_top.sv
`timescale 1ns/1ps
module slot_regmap_dma_tb_top;
    import srd_pkg::*;

    localparam int AW  = 32;
    localparam int SIW = 4;
    localparam int SHW = 5;
    localparam logic [31:0] QB  = 32'h0000_0100;
    localparam logic [31:0] SS  = 32'h0000_0040;
    localparam logic [31:0] UB  = 32'h8000_0000;
    localparam int          USH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          busy, done, rd_req, wr_valid;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0]   wr_data;
    logic          rd_valid = 1'b0;
    logic [31:0]   rd_data = '0;
    logic          wr_ready = 1'b1;
    logic          stall_en = 1'b0;
    logic [1:0]    cyc = '0;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    logic [31:0] mem    [0:1023];
    logic [31:0] rd_log [0:255];
    logic [31:0] wa_log [0:255];
    logic [31:0] wd_log [0:255];

    always #2.5 clk = ~clk;

    slot_regmap_dma #(.ADDR_W(AW), .SLOT_IDX_W(SIW), .SHIFT_W(SHW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    // memory model: data one cycle after the request
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rd_req) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[rd_addr[11:2]];
            rd_log[rd_cnt[7:0]] <= rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
        cyc <= cyc + 2'd1;
        wr_ready <= !stall_en || (cyc == 2'b10);
    end

    always @(negedge clk) begin
        if (wr_valid && wr_ready) begin
            wa_log[wr_cnt[7:0]] <= wr_addr;
            wd_log[wr_cnt[7:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    function automatic logic [31:0] pat(int s, int k);
        return 32'hA500_0000 | (32'(s) << 8) | 32'(k);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_slot(int s, int cnt, int xm, logic [31:0] m0, logic [31:0] m1,
                            logic [31:0] m2, logic [31:0] m3, logic [31:0] junk);
        int b = int'((QB + 32'(s) * SS) >> 2);
        int n = cnt - (1 + xm);
        mem[b]   = (junk & ~32'h007F_FC00) | (32'(cnt) << 12) | (32'(xm) << 10);
        mem[b+1] = m0; mem[b+2] = m1; mem[b+3] = m2; mem[b+4] = m3;
        for (int k = 0; k < n; k++) mem[b + 2 + xm + k] = pat(s, k);
    endtask

    task automatic wait_done(string req, int base, int n);
        int lim = 0;
        while (done_cnt < base + n && lim < 3000) begin
            @(negedge clk);
            lim++;
        end
        chk(req, 32'(done_cnt - base), 32'(n));
    endtask

    task automatic check_copy(string req, int wbase, int s, int unit, int n);
        for (int k = 0; k < n; k++) begin
            chk(req, wa_log[(wbase + k) % 256], UB + (32'(unit) << USH) + 32'(4 * k));
            chk(req, wd_log[(wbase + k) % 256], pat(s, k));
        end
    endtask

    // one triggered copy with full result checking
    task automatic run_one(string req, int s, int unit, int nw, int nrd);
        int wb = wr_cnt;
        int rb = rd_cnt;
        int db = done_cnt;
        cfg_wr(CFG_TRIG, 32'(s));
        chk({req, " R10 busy after trigger"}, 32'(busy), 32'd1);
        wait_done({req, " R7 done"}, db, 1);
        @(negedge clk);
        chk({req, " R10 idle after done"}, 32'(busy), 32'd0);
        chk({req, " R2 header address"}, rd_log[rb % 256], QB + 32'(s) * SS);
        chk({req, " R12 read count"}, 32'(rd_cnt - rb), 32'(nrd));
        chk({req, " write count"}, 32'(wr_cnt - wb), 32'(nw));
        check_copy({req, " R5 map"}, wb, s, unit, nw);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 rd_req", 32'(rd_req), 32'd0);
        chk("R1 wr_valid", 32'(wr_valid), 32'd0);
    endtask

    task automatic t_basic();
        put_slot(2, 5, 0, 32'h0000_0008, 0, 0, 0, 0);
        run_one("R5 basic", 2, 3, 4, 6);
    endtask

    task automatic t_extra();
        put_slot(5, 6, 2, 0, 0, 32'h0000_0020, 0, 0);
        run_one("R4 third mask word", 5, 69, 3, 7);
    endtask

    task automatic t_lowest();
        put_slot(6, 3, 1, 32'h0000_0120, 32'h0000_FFFF, 0, 0, 0);
        run_one("R4 lowest bit, early stop", 6, 5, 1, 3);
    endtask

    task automatic t_empty();
        put_slot(7, 1, 0, 32'h1, 0, 0, 0, 0);
        run_one("R6 empty map", 7, 0, 0, 2);
    endtask

    task automatic t_short();
        put_slot(8, 1, 2, 32'h1, 0, 0, 0, 0);
        run_one("R6 underflow count", 8, 0, 0, 2);
    endtask

    task automatic t_nomask();
        put_slot(9, 4, 1, 0, 0, 0, 0, 0);
        run_one("R8 zero masks", 9, 0, 0, 3);
    endtask

    task automatic t_junk();
        put_slot(10, 4, 0, 32'h8000_0000, 0, 0, 0, 32'hFFFF_FFFF);
        run_one("R3 ignored header bits", 10, 31, 3, 5);
    endtask

    task automatic t_stall();
        stall_en = 1'b1;
        put_slot(11, 7, 0, 32'h1, 0, 0, 0, 0);
        run_one("R9 write backpressure", 11, 0, 6, 8);
        stall_en = 1'b0;
    endtask

    task automatic t_pending();
        int wb = wr_cnt;
        int db = done_cnt;
        put_slot(3, 3, 0, 32'h2, 0, 0, 0, 0);
        put_slot(4, 4, 0, 32'h4, 0, 0, 0, 0);
        put_slot(12, 2, 0, 32'h1, 0, 0, 0, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CFG_TRIG; cfg_wdata = 32'd3;
        @(negedge clk);
        cfg_wdata = 32'd4;
        @(negedge clk);
        cfg_wdata = 32'd12;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_done("R10 queued copy done", db, 2);
        repeat (100) @(negedge clk);
        chk("R11 dropped trigger, done count", 32'(done_cnt - db), 32'd2);
        chk("R11 dropped trigger, write count", 32'(wr_cnt - wb), 32'd5);
        chk("R10 idle after both", 32'(busy), 32'd0);
        check_copy("R10 first copy", wb, 3, 1, 2);
        check_copy("R10 second copy", wb + 2, 4, 2, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_wr(CFG_QBASE,  QB);
        cfg_wr(CFG_SLOTSZ, SS);
        cfg_wr(CFG_UBASE,  UB);
        cfg_wr(CFG_USHIFT, 32'(USH));
        t_basic();
        t_extra();
        t_lowest();
        t_empty();
        t_short();
        t_nomask();
        t_junk();
        t_stall();
        t_pending();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule